// File: doc/BRIEF.md
# Chainable Periodic Interrupt Timer

A bank of down-counting interval timers behind a small word-addressed register window. Each channel is given a reload value, switched on, and then counts down once per bus clock. When a count of zero is consumed it raises a sticky expiry flag and starts over from the reload value, which gives a period of reload + 1 counting cycles. Software clears the flag by writing a one to it. A per-channel interrupt line follows the flag when interrupts are enabled for that channel.

Any channel except the lowest can be linked to its lower neighbour. A linked channel then decrements once per expiry of that neighbour instead of once per clock, so the neighbour acts as a prescaler and long intervals can be built from two or more channels. A global control register holds the block in a stopped state after reset, and can also stall all counting while an external debug-halt input is high.

Top module: `chain_pit`

## Requirements
- R1: After reset the global control register reads 0x2 (bit 1 stop = 1, bit 0 debug-stall = 0), every channel register reads 0 and all interrupt outputs are low.
- R2: The global control register sits at byte address 0x000. Channel n occupies the 16-byte slot at 0x100 + 16*n, with reload value at +0x0, current count at +0x4, control at +0x8 and flag at +0xC. Control bit 0 is run, bit 1 is interrupt enable and bit 2 is link-to-lower. The flag is bit 0. Any other address reads 0.
- R3: When the run bit changes from 0 to 1, the count is set to the reload value at that write edge, whether or not the block is stopped.
- R4: A running channel's count drops by one per counting cycle. On the counting cycle that finds the count at zero, the count takes the reload value and the flag is set.
- R5: Writing the reload value leaves the current count untouched. The new value is taken at the next reload.
- R6: Writing 1 to flag bit 0 clears the flag and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R7: A channel's interrupt output is high exactly when both its flag and its interrupt-enable bit are set.
- R8: With the link bit set on channel n >= 1, channel n counts once per expiry of channel n-1. Channel 0 cannot be linked, and its link bit always reads 0.
- R9: While the stop bit is set, or while the debug-stall bit and the debug-halt input are both high, no channel counts. With the debug-stall bit clear, the debug-halt input has no effect.
- R10: Clearing the run bit stops the channel and holds its current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt_i | input | 1 | Debug-halt request from the processor |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr_i | input | 9 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 4 | Per-channel interrupt request |

## Verification
The counting path is exercised from a table of reload values and elapsed-cycle counts. The table covers sampling on the enable edge, in mid-count, at the cycle that reaches zero, on the cycle that reloads and some cycles after it, and a reload of zero that expires every cycle. Together these separate an off-by-one period, a missing reload and a flag that sets one cycle early or late. Directed cases follow. A reload written in mid-count separates deferred from immediate loading. A clear that coincides with an expiry fixes the priority between the two. Toggling debug-halt with the stall bit both set and clear separates the freeze gating from plain halting. A linked pair separates per-expiry counting from per-clock counting.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 9;

   typedef enum logic [1:0] {
      SLOT_RELOAD = 2'd0,
      SLOT_COUNT  = 2'd1,
      SLOT_CTRL   = 2'd2,
      SLOT_FLAG   = 2'd3
   } slot_reg_e;

   localparam int CTL_RUN  = 0;
   localparam int CTL_IEN  = 1;
   localparam int CTL_LINK = 2;
   localparam int GBL_STALL = 0;
   localparam int GBL_STOP  = 1;
endpackage

// File: rtl/pit_bus_dec.sv
module pit_bus_dec
   import pit_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              gbl_hit_o,
   output logic              ch_hit_o,
   output logic [3:0]        ch_idx_o,
   output slot_reg_e         reg_sel_o
);
   logic aligned;

   assign aligned   = (addr_i[1:0] == 2'b00);
   assign ch_idx_o  = addr_i[7:4];
   assign reg_sel_o = slot_reg_e'(addr_i[3:2]);
   assign gbl_hit_o = (addr_i == '0);
   assign ch_hit_o  = addr_i[8] && aligned && (32'(addr_i[7:4]) < NUM_CH);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter bit HAS_CHAIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   input  logic              wr_reload_i,
   input  logic              wr_ctrl_i,
   input  logic              wr_flag_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              prev_exp_i,
   output logic [CNT_W-1:0]  reload_o,
   output logic [CNT_W-1:0]  count_o,
   output logic [2:0]        ctrl_o,
   output logic              flag_o,
   output logic              exp_o,
   output logic              irq_o
);
   logic [CNT_W-1:0] reload_q, count_q;
   logic run_q, ien_q, link_q, flag_q;
   logic start, tick, step;

   assign start = wr_ctrl_i && wdata_i[CTL_RUN] && !run_q;
   assign tick  = link_q ? prev_exp_i : 1'b1;
   assign step  = run_q && !halt_i && tick;
   assign exp_o = step && (count_q == '0);

   generate
      if (HAS_CHAIN) begin : g_link
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          link_q <= 1'b0;
            else if (wr_ctrl_i)  link_q <= wdata_i[CTL_LINK];
         end
      end else begin : g_nolink
         assign link_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         count_q  <= '0;
         run_q    <= 1'b0;
         ien_q    <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (wr_reload_i) reload_q <= wdata_i[CNT_W-1:0];
         if (wr_ctrl_i) begin
            run_q <= wdata_i[CTL_RUN];
            ien_q <= wdata_i[CTL_IEN];
         end
         if (start)                count_q <= reload_q;
         else if (exp_o)           count_q <= reload_q;
         else if (step)            count_q <= count_q - 1'b1;
         if (exp_o)                          flag_q <= 1'b1;
         else if (wr_flag_i && wdata_i[0])   flag_q <= 1'b0;
      end
   end

   assign reload_o = reload_q;
   assign count_o  = count_q;
   assign ctrl_o   = {link_q, ien_q, run_q};
   assign flag_o   = flag_q;
   assign irq_o    = flag_q && ien_q;

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> count_q == $past(reload_q));                            // R3
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step && count_q != '0) |=> count_q == $past(count_q) - 1'b1);     // R4
   AST_RELOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      exp_o |=> (flag_q && count_q == $past(reload_q)));                 // R4
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag_i && wdata_i[0] && !exp_o) |=> !flag_q);                  // R6
   AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag_i && !wdata_i[0] && flag_q) |=> flag_q);                  // R6
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i && !start) |=> $stable(count_q));                          // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start) |=> $stable(count_q));                          // R10
endmodule

// File: rtl/chain_pit.sv
module chain_pit
   import pit_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_halt_i,
   input  logic              bus_wr_i,
   input  logic [8:0]        bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);
   generate
      if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_nch
         $error("NUM_CH must lie in 2..16");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cntw
         $error("CNT_W must lie in 1..32");
      end
   endgenerate

   logic gbl_hit, ch_hit, halt;
   logic [3:0] ch_idx;
   slot_reg_e  reg_sel;
   logic stop_q, stall_q;

   logic [CNT_W-1:0] reload_v [NUM_CH];
   logic [CNT_W-1:0] count_v  [NUM_CH];
   logic [2:0]       ctrl_v   [NUM_CH];
   logic [NUM_CH-1:0] flag_v, exp_v;

   pit_bus_dec #(.NUM_CH(NUM_CH)) u_dec (
      .addr_i    (bus_addr_i),
      .gbl_hit_o (gbl_hit),
      .ch_hit_o  (ch_hit),
      .ch_idx_o  (ch_idx),
      .reg_sel_o (reg_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q  <= 1'b1;
         stall_q <= 1'b0;
      end else if (bus_wr_i && gbl_hit) begin
         stop_q  <= bus_wdata_i[GBL_STOP];
         stall_q <= bus_wdata_i[GBL_STALL];
      end
   end

   assign halt = stop_q || (stall_q && dbg_halt_i);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic sel;
         logic prev_exp;
         assign sel = bus_wr_i && ch_hit && (32'(ch_idx) == i);
         if (i == 0) begin : g_first
            assign prev_exp = 1'b0;
         end else begin : g_next
            assign prev_exp = exp_v[i-1];
         end
         pit_channel #(.CNT_W(CNT_W), .HAS_CHAIN(i != 0)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .halt_i      (halt),
            .wr_reload_i (sel && reg_sel == SLOT_RELOAD),
            .wr_ctrl_i   (sel && reg_sel == SLOT_CTRL),
            .wr_flag_i   (sel && reg_sel == SLOT_FLAG),
            .wdata_i     (bus_wdata_i),
            .prev_exp_i  (prev_exp),
            .reload_o    (reload_v[i]),
            .count_o     (count_v[i]),
            .ctrl_o      (ctrl_v[i]),
            .flag_o      (flag_v[i]),
            .exp_o       (exp_v[i]),
            .irq_o       (irq_o[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata_o = '0;
      if (gbl_hit) begin
         bus_rdata_o[GBL_STOP]  = stop_q;
         bus_rdata_o[GBL_STALL] = stall_q;
      end else if (ch_hit) begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (32'(ch_idx) == k) begin
               unique case (reg_sel)
                  SLOT_RELOAD: bus_rdata_o = DATA_W'(reload_v[k]);
                  SLOT_COUNT:  bus_rdata_o = DATA_W'(count_v[k]);
                  SLOT_CTRL:   bus_rdata_o = DATA_W'(ctrl_v[k]);
                  SLOT_FLAG:   bus_rdata_o = DATA_W'(flag_v[k]);
               endcase
            end
         end
      end
   end

   AST_FIRST_UNLINKED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_v[0][CTL_LINK]);                                             // R8
   AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> exp_v == '0);                                             // R9
endmodule

// File: tb/chain_pit_tb.sv
`timescale 1ns/1ps
module chain_pit_tb;
   logic clk = 1'b0;
   logic rst_n;
   logic dbg_halt;
   logic bus_wr;
   logic [8:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   chain_pit u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .dbg_halt_i  (dbg_halt),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq)
   );

   typedef struct packed {
      logic [31:0] ld;
      logic [31:0] waits;
      logic [31:0] cnt;
      logic [31:0] flg;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{32'd5,    32'd0,  32'd5,   32'd0},
      '{32'd5,    32'd3,  32'd2,   32'd0},
      '{32'd5,    32'd5,  32'd0,   32'd0},
      '{32'd5,    32'd6,  32'd5,   32'd1},
      '{32'd5,    32'd8,  32'd3,   32'd1},
      '{32'd0,    32'd1,  32'd0,   32'd1},
      '{32'd0,    32'd0,  32'd0,   32'd0},
      '{32'd1000, 32'd10, 32'd990, 32'd0}
   };

   function automatic logic [8:0] ca(input int ch, input int rg);
      return 9'(32'h100 + ch * 16 + rg * 4);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      finish_run();
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; dbg_halt = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(9'h000, d);   chk("R1 global ctrl", d, 32'h2);
      rd(ca(0,0), d);  chk("R1 reload0", d, 32'h0);
      rd(ca(2,2), d);  chk("R1 ctrl2", d, 32'h0);
      rd(ca(3,1), d);  chk("R1 count3", d, 32'h0);
      chk("R1 irq", {28'h0, irq}, 32'h0);

      // R9 stopped block; R3 start still loads
      wr(ca(0,0), 32'd3);
      wr(ca(0,2), 32'd1);
      wait_cyc(4);
      rd(ca(0,1), d);  chk("R9 stop holds / R3 load", d, 32'd3);
      wr(9'h000, 32'h0);
      wait_cyc(2);
      rd(ca(0,1), d);  chk("R4 counts after unstop", d, 32'd1);

      // R4 table walk
      for (int v = 0; v < 8; v++) begin
         wr(ca(0,2), 32'h0);
         wr(ca(0,3), 32'h1);
         wr(ca(0,0), VEC[v].ld);
         wr(ca(0,2), 32'h1);
         wait_cyc(int'(VEC[v].waits));
         rd(ca(0,1), d);  chk($sformatf("R4 vec%0d count", v), d, VEC[v].cnt);
         rd(ca(0,3), d);  chk($sformatf("R4 vec%0d flag", v), d, VEC[v].flg);
      end

      // R10 stop holds count
      wr(ca(0,2), 32'h0);
      wr(ca(0,3), 32'h1);
      wr(ca(0,0), 32'd20);
      wr(ca(0,2), 32'h1);
      wait_cyc(3);
      rd(ca(0,1), d);  chk("R10 running", d, 32'd17);
      wr(ca(0,2), 32'h0);
      wait_cyc(4);
      rd(ca(0,1), d);  chk("R10 held", d, 32'd16);

      // R5 reload written mid-count
      wr(ca(0,0), 32'd10);
      wr(ca(0,2), 32'h1);
      wait_cyc(2);
      wr(ca(0,0), 32'd3);
      rd(ca(0,1), d);  chk("R5 count undisturbed", d, 32'd7);
      rd(ca(0,0), d);  chk("R5 reload readback", d, 32'd3);
      wait_cyc(7);
      rd(ca(0,1), d);  chk("R5 reached zero", d, 32'd0);
      wait_cyc(1);
      rd(ca(0,1), d);  chk("R5 new reload used", d, 32'd3);
      rd(ca(0,3), d);  chk("R5 flag", d, 32'd1);

      // R7 interrupt gating
      chk("R7 irq masked", {28'h0, irq}, 32'h0);
      wr(ca(0,2), 32'h3);
      chk("R7 irq enabled", {28'h0, irq}, 32'h1);

      // R6 write-one-to-clear
      wr(ca(0,2), 32'h2);
      wr(ca(0,3), 32'h0);
      rd(ca(0,3), d);  chk("R6 write 0 keeps", d, 32'd1);
      wr(ca(0,3), 32'h1);
      rd(ca(0,3), d);  chk("R6 write 1 clears", d, 32'd0);
      chk("R7 irq drops", {28'h0, irq}, 32'h0);
      wr(ca(0,0), 32'd0);
      wr(ca(0,2), 32'h1);
      wr(ca(0,3), 32'h1);
      rd(ca(0,3), d);  chk("R6 expiry beats clear", d, 32'd1);
      wr(ca(0,2), 32'h0);
      wr(ca(0,3), 32'h1);

      // R9 debug stall
      wr(9'h000, 32'h1);
      dbg_halt = 1'b1;
      wr(ca(0,0), 32'd5);
      wr(ca(0,2), 32'h1);
      wait_cyc(3);
      rd(ca(0,1), d);  chk("R9 stalled", d, 32'd5);
      dbg_halt = 1'b0;
      wait_cyc(3);
      rd(ca(0,1), d);  chk("R9 resumed", d, 32'd2);
      dbg_halt = 1'b1;
      wr(9'h000, 32'h0);
      wait_cyc(2);
      rd(ca(0,1), d);  chk("R9 halt ignored w/o stall", d, 32'd0);
      dbg_halt = 1'b0;
      wr(ca(0,2), 32'h0);
      wr(ca(0,3), 32'h1);

      // R8 linked pair
      wr(ca(0,0), 32'd2);
      wr(ca(1,0), 32'd1);
      wr(ca(1,2), 32'h5);
      wr(ca(0,2), 32'h1);
      wait_cyc(5);
      rd(ca(1,1), d);  chk("R8 linked count", d, 32'd0);
      rd(ca(1,3), d);  chk("R8 linked flag low", d, 32'd0);
      wait_cyc(1);
      rd(ca(1,1), d);  chk("R8 linked reload", d, 32'd1);
      rd(ca(1,3), d);  chk("R8 linked flag", d, 32'd1);
      wr(ca(0,2), 32'h7);
      rd(ca(0,2), d);  chk("R8 ch0 link bit", d, 32'h3);

      // R2 map
      wr(ca(3,0), 32'hDEADBEEF);
      rd(ca(3,0), d);  chk("R2 ch3 reload", d, 32'hDEADBEEF);
      rd(ca(2,0), d);  chk("R2 ch2 untouched", d, 32'h0);
      rd(9'h004, d);   chk("R2 unmapped", d, 32'h0);

      finish_run();
   end
endmodule